// File: doc/BRIEF.md
# Vectored interrupt priority controller

This block turns up to 32 level interrupt requests into one vector address for a processor's interrupt entry code. The requests are first reduced to the pending normal set by two programmable masks: one enables sources, and one claims sources for the fast-interrupt path. Sources claimed for the fast path are removed from the normal set.

Sixteen programmable slots then map interrupt sources to vector addresses. Each slot names one source, has an enable bit, and holds a 32-bit address. The slots are searched in a fixed priority order. A read of the vector register returns the address of the winning slot. If no slot wins, the read returns a programmable default address. Every such read also stores the returned value in a current-vector register. The irq output tells the processor that at least one normal request is pending.

All programming goes through a simple word-addressed register bus. Writes take effect on the next clock edge. Read data is combinational while the read strobe is high.

Top module: `vic_slot_prio`

## Requirements
- R1: The pending normal set is the raw request vector AND the enable mask (address 0x00) AND the inverse of the fast-select mask (address 0x01). A source that is masked out or claimed for the fast path never selects a slot.
- R2: When several slots match, the slot with the lowest index wins. Slot 0 has the highest priority. When two slots name the same source, the lower index supplies the vector.
- R3: In a slot control register, bit 5 enables the slot and bits 4:0 give its source number (0 to 31). A disabled slot is skipped even when its source is pending. Source 31 is reachable.
- R4: A vector read (address 0x03) returns the default vector register (address 0x02) when the pending normal set is empty.
- R5: A vector read returns the default vector when requests are pending but no enabled slot names any of them.
- R6: Every vector read loads the value it returned into the current-vector register. The new value shows on cur_vector and at address 0x04 from the next cycle. With no vector read, the register holds its value.
- R7: The register map is as follows:
  - Slot control registers are at 0x10+i.
  - Slot vector addresses are at 0x20+i.
  - Written values read back unchanged at the same address.
  - Writes to 0x03 and 0x04 have no effect.
- R8: After reset, these registers are all zero:
  - the masks;
  - the default vector;
  - the current vector;
  - every slot address.
  
  Every slot is disabled, so with no programming a vector read returns 0 and irq_o stays low.
- R9: irq_o is high in the same cycle as any bit of the pending normal set is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_raw | input | 32 | Raw level interrupt requests, one bit per source |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ren is high |
| irq_o | output | 1 | High while any normal interrupt is pending |
| cur_vector | output | 32 | Current-vector register |

## Verification
The vector read is tried with several request patterns:
- a single request that hits a high slot and one that hits a low slot;
- two requests at once, to tell priority order from match order;
- a request whose slot is disabled, and a request with no slot at all, to tell the skip rule from the fallback;
- a request on source 31, for the top bit of the source field.

The mask checks rerun a two-request pattern after disabling the winner, and then claim a source for the fast path. This shows both masks feeding the pending set. A duplicate mapping of one source to two slots confirms that the slot index, not the programming order, decides the winner. Each read's expected value is queued and compared against both the read data and the current vector one edge later.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NUM_SRC  = 32;
  localparam int unsigned NUM_SLOT = 16;
  localparam int unsigned VEC_W    = 32;
  localparam int unsigned REG_AW   = 6;
  localparam int unsigned SRC_W    = $clog2(NUM_SRC);
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOT);

  localparam logic [REG_AW-1:0] A_ENABLE  = 6'h00;
  localparam logic [REG_AW-1:0] A_FSEL    = 6'h01;
  localparam logic [REG_AW-1:0] A_DEFAULT = 6'h02;
  localparam logic [REG_AW-1:0] A_VECT    = 6'h03;
  localparam logic [REG_AW-1:0] A_CURRENT = 6'h04;
  // slot regions: upper two address bits pick the region, low bits the slot
  localparam logic [1:0] RGN_CTRL = 2'b01;
  localparam logic [1:0] RGN_ADDR = 2'b10;
  localparam int unsigned CTRL_EN_BIT = SRC_W;
endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/vic_slot_bank.sv
module vic_slot_bank #(
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned SRC_W    = 5,
  parameter int unsigned VEC_W    = 32,
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_ctrl,
  input  logic                              wr_vec,
  input  logic [SLOT_W-1:0]                 wr_idx,
  input  logic [VEC_W-1:0]                  wdata,
  output logic [NUM_SLOT-1:0]               slot_en,
  output logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_src,
  output logic [NUM_SLOT-1:0][VEC_W-1:0]    slot_vec
);
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    logic             en_d;
    logic [SRC_W-1:0] src_d;
    logic [VEC_W-1:0] vec_d;
    logic             ctrl_ce, vec_ce;

    assign ctrl_ce = wr_ctrl && (wr_idx == SLOT_W'(g));
    assign vec_ce  = wr_vec  && (wr_idx == SLOT_W'(g));

    always_comb begin
      en_d  = slot_en[g];
      src_d = slot_src[g];
      vec_d = slot_vec[g];
      if (ctrl_ce) begin
        en_d  = wdata[SRC_W];
        src_d = wdata[SRC_W-1:0];
      end
      if (vec_ce) vec_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_en[g]  <= 1'b0;
        slot_src[g] <= '0;
        slot_vec[g] <= '0;
      end else begin
        slot_en[g]  <= en_d;
        slot_src[g] <= src_d;
        slot_vec[g] <= vec_d;
      end
    end
  end
endmodule

// File: rtl/vic_prio_scan.sv
module vic_prio_scan #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned VEC_W    = 32,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SLOT-1:0]            slot_en,
  input  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src,
  input  logic [NUM_SLOT-1:0][VEC_W-1:0] slot_vec,
  input  logic [VEC_W-1:0]               dflt,
  output logic                           hit,
  output logic [SLOT_W-1:0]              win_idx,
  output logic [VEC_W-1:0]               vec_out
);
  logic [NUM_SLOT-1:0] match;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_match
    assign match[g] = slot_en[g] && pend[slot_src[g]];
  end

  // highest index first so the lowest matching index is assigned last
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    vec_out = dflt;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        win_idx = SLOT_W'(i);
        vec_out = slot_vec[i];
      end
    end
  end
endmodule

// File: rtl/vic_slot_prio.sv
module vic_slot_prio
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_raw,
  input  logic               bus_wen,
  input  logic               bus_ren,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [VEC_W-1:0]   bus_wdata,
  output logic [VEC_W-1:0]   bus_rdata,
  output logic               irq_o,
  output logic [VEC_W-1:0]   cur_vector
);
  logic                           rst_sn;
  logic [NUM_SRC-1:0]             en_q, en_d, fsel_q, fsel_d, pend;
  logic [VEC_W-1:0]               dflt_q, dflt_d, cur_q, cur_d, scan_vec;
  logic [NUM_SLOT-1:0]            slot_en;
  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src;
  logic [NUM_SLOT-1:0][VEC_W-1:0] slot_vec;
  logic                           scan_hit;
  logic [SLOT_W-1:0]              scan_win, sel_idx;
  logic                           in_ctrl, in_addr, vec_rd;

  vic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign sel_idx = bus_addr[SLOT_W-1:0];
  assign in_ctrl = bus_addr[REG_AW-1:REG_AW-2] == RGN_CTRL;
  assign in_addr = bus_addr[REG_AW-1:REG_AW-2] == RGN_ADDR;
  assign vec_rd  = bus_ren && (bus_addr == A_VECT);
  assign pend    = irq_raw & en_q & ~fsel_q;
  assign irq_o   = |pend;

  vic_slot_bank #(.NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_bank (
    .clk(clk), .rst_n(rst_sn),
    .wr_ctrl(bus_wen && in_ctrl), .wr_vec(bus_wen && in_addr),
    .wr_idx(sel_idx), .wdata(bus_wdata),
    .slot_en(slot_en), .slot_src(slot_src), .slot_vec(slot_vec)
  );

  vic_prio_scan #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .VEC_W(VEC_W)) u_scan (
    .pend(pend), .slot_en(slot_en), .slot_src(slot_src), .slot_vec(slot_vec),
    .dflt(dflt_q), .hit(scan_hit), .win_idx(scan_win), .vec_out(scan_vec)
  );

  always_comb begin
    en_d   = en_q;
    fsel_d = fsel_q;
    dflt_d = dflt_q;
    cur_d  = cur_q;
    if (bus_wen && bus_addr == A_ENABLE)  en_d   = bus_wdata[NUM_SRC-1:0];
    if (bus_wen && bus_addr == A_FSEL)    fsel_d = bus_wdata[NUM_SRC-1:0];
    if (bus_wen && bus_addr == A_DEFAULT) dflt_d = bus_wdata;
    if (vec_rd)                           cur_d  = scan_vec;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q   <= '0;
      fsel_q <= '0;
      dflt_q <= '0;
      cur_q  <= '0;
    end else begin
      en_q   <= en_d;
      fsel_q <= fsel_d;
      dflt_q <= dflt_d;
      cur_q  <= cur_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_ren) begin
      if (in_ctrl)                     bus_rdata = VEC_W'({slot_en[sel_idx], slot_src[sel_idx]});
      else if (in_addr)                bus_rdata = slot_vec[sel_idx];
      else if (bus_addr == A_ENABLE)   bus_rdata = VEC_W'(en_q);
      else if (bus_addr == A_FSEL)     bus_rdata = VEC_W'(fsel_q);
      else if (bus_addr == A_DEFAULT)  bus_rdata = dflt_q;
      else if (bus_addr == A_VECT)     bus_rdata = scan_vec;
      else if (bus_addr == A_CURRENT)  bus_rdata = cur_q;
    end
  end

  assign cur_vector = cur_q;
endmodule

// File: rtl/vic_slot_prio_chk.sv
module vic_slot_prio_chk
  import vic_pkg::*;
(
  input logic                           clk,
  input logic                           rst_sn,
  input logic                           bus_ren,
  input logic [REG_AW-1:0]              bus_addr,
  input logic [VEC_W-1:0]               bus_rdata,
  input logic                           irq_o,
  input logic [VEC_W-1:0]               cur_vector,
  input logic [VEC_W-1:0]               dflt,
  input logic [NUM_SRC-1:0]             pend,
  input logic [NUM_SLOT-1:0]            slot_en,
  input logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src,
  input logic                           hit,
  input logic [SLOT_W-1:0]              win
);
  logic vrd;
  assign vrd = bus_ren && (bus_addr == A_VECT);

  AST_WIN_IS_ENABLED: assert property (@(posedge clk) disable iff (!rst_sn)
    hit |-> (slot_en[win] && pend[slot_src[win]])); // R3

  AST_IDLE_GIVES_DEFAULT: assert property (@(posedge clk) disable iff (!rst_sn)
    (vrd && !irq_o) |-> (bus_rdata == dflt)); // R4

  AST_MISS_GIVES_DEFAULT: assert property (@(posedge clk) disable iff (!rst_sn)
    (vrd && !hit) |-> (bus_rdata == dflt)); // R5

  AST_HIT_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_sn)
    hit |-> irq_o); // R9

  AST_CUR_LOADS: assert property (@(posedge clk) disable iff (!rst_sn)
    vrd |=> (cur_vector == $past(bus_rdata))); // R6

  AST_CUR_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    !vrd |=> $stable(cur_vector)); // R6
endmodule

bind vic_slot_prio vic_slot_prio_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_ren(bus_ren), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .cur_vector(cur_vector),
  .dflt(dflt_q), .pend(pend), .slot_en(slot_en), .slot_src(slot_src),
  .hit(scan_hit), .win(scan_win)
);

// File: tb/vic_slot_prio_tb_top.sv
`timescale 1ns/1ps
module vic_slot_prio_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_raw = '0;
  logic        bus_wen = 1'b0;
  logic        bus_ren = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [31:0] cur_vector;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  vic_slot_prio dut_i (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .bus_wen(bus_wen),
    .bus_ren(bus_ren), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .cur_vector(cur_vector)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  // driver: queue the expected vector, then issue the read
  task automatic vec_read(input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = 6'h03;
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  task automatic set_raw(input logic [31:0] v);
    @(negedge clk);
    irq_raw = v;
    #1;
  endtask

  // monitor: compare read data at the edge and the current vector just after
  initial begin
    forever begin
      @(posedge clk);
      if (bus_ren && bus_addr == 6'h03) begin
        logic [31:0] got;
        logic [31:0] e;
        string t;
        got = bus_rdata;
        #1;
        if (exp_q.size() == 0) begin
          chk("R6 unexpected vector read", 32'h1, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, got, e);
          chk({"R6 latch after ", t}, cur_vector, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    chk("R8 cur_vector", cur_vector, 32'h0);
    rd(6'h10, v); chk("R8 slot0 ctrl", v, 32'h0);
    rd(6'h25, v); chk("R8 slot5 addr", v, 32'h0);
    set_raw(32'hFFFF_FFFF);
    chk("R8 irq masked after reset", {31'h0, irq_o}, 32'h0);
    vec_read(32'h0, "R8 vector default zero");
    set_raw(32'h0);

    wr(6'h02, 32'hDEAD_0000);
    vec_read(32'hDEAD_0000, "R4 nothing pending");

    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h10, 32'h25); wr(6'h20, 32'h100);
    wr(6'h13, 32'h29); wr(6'h23, 32'h300);
    wr(6'h17, 32'h0C); wr(6'h27, 32'h700);
    wr(6'h1F, 32'h3F); wr(6'h2F, 32'hF00);
    rd(6'h13, v); chk("R7 R3 slot3 ctrl readback", v, 32'h29);
    rd(6'h2F, v); chk("R7 slot15 addr readback", v, 32'hF00);

    set_raw(32'h1 << 5);
    chk("R9 irq with pending", {31'h0, irq_o}, 32'h1);
    vec_read(32'h100, "R3 source 5 to slot 0");
    set_raw(32'h1 << 9);
    vec_read(32'h300, "R3 source 9 to slot 3");
    set_raw((32'h1 << 5) | (32'h1 << 9));
    vec_read(32'h100, "R2 slot 0 over slot 3");
    set_raw(32'h1 << 12);
    vec_read(32'hDEAD_0000, "R3 disabled slot skipped");
    set_raw(32'h1 << 31);
    vec_read(32'hF00, "R3 source 31");
    set_raw(32'h1 << 20);
    chk("R9 irq with unmapped pending", {31'h0, irq_o}, 32'h1);
    vec_read(32'hDEAD_0000, "R5 pending but no slot");
    rd(6'h04, v); chk("R6 current readable", v, 32'hDEAD_0000);

    wr(6'h00, ~(32'h1 << 5));
    set_raw((32'h1 << 5) | (32'h1 << 9));
    vec_read(32'h300, "R1 enable mask drops source 5");
    set_raw(32'h1 << 5);
    chk("R1 R9 masked source no irq", {31'h0, irq_o}, 32'h0);
    vec_read(32'hDEAD_0000, "R4 masked only");

    wr(6'h01, 32'h1 << 9);
    set_raw(32'h1 << 9);
    chk("R1 fast-select removes irq", {31'h0, irq_o}, 32'h0);
    vec_read(32'hDEAD_0000, "R1 fast-select source not vectored");

    wr(6'h01, 32'h0);
    wr(6'h12, 32'h29); wr(6'h22, 32'h200);
    vec_read(32'h200, "R2 duplicate source lower slot");

    repeat (3) @(negedge clk);
    chk("R6 hold without read", cur_vector, 32'h200);
    wr(6'h04, 32'h1234_5678);
    wr(6'h03, 32'h1234_5678);
    rd(6'h04, v); chk("R7 write to current ignored", v, 32'h200);
    chk("R7 cur_vector unchanged", cur_vector, 32'h200);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule